// File: doc/BRIEF.md
# Multi-Antenna Pilot Channel Estimator

This block measures the channel impulse responses from four transmit antennas to a single receive antenna. Each transmit antenna sends the same scrambling sequence, multiplied by its own binary orthogonal spreading code. The receiver correlates its complex baseband samples against these binary pilots. Every pilot value is plus or minus one, so the block needs no multiplier. It uses only adders and negations.

The work splits into two stages. The first is a single 16-tap filter shared by all antennas. Its coefficients are the scrambling chips combined with the low four bits of the code, which all antennas must share. It produces one partial correlation per strobed sample, and those partials cycle through the 16 lags. The second stage has one lane per antenna. Each lane folds the partials into a 16-entry accumulator, adding or subtracting them according to that antenna's high code bits for the current block of 16 chips. An averaging period spans `16·R` chips, where R is a block count read from a configuration input. At the end of each period the 64 complex taps are streamed out, ordered first by antenna and then by lag. If the antennas' low code bits differ, the shared filter is invalid. The block then raises an error flag and suppresses its output.

Top module: `pilot_chan_est`

## Requirements
- R1: While `rst` is high and on the first clock after it, `tap_vld` is 0, `cfg_err` is 0 when the low code bits agree, and `tap_re`/`tap_im` are 0.
- R2: Count samples from the start of a period as x(0), x(1), and so on, with only strobed samples counted. Let the period length be K. The tap of antenna i at lag d (0..15) equals the sum, over k = 0..K-1, of x(k+d)·c_i(k). Here c_i(k) = −1 when `pn_chip(k)` XOR parity(k[7:0] AND code_i) is 1, and +1 otherwise. The sum is taken separately for the real and imaginary parts.
- R3: R is sampled from `blk_cfg` during reset and again on the strobe that ends a period. A change in the middle of a period therefore takes effect from the next period.
- R4: A sampled `blk_cfg` below 5 is treated as 5, so K = 16·max(R, 5).
- R5: After each period, 64 taps appear with `tap_vld` high on 64 consecutive clocks. `tap_ant` runs over 0..3, and within each antenna `tap_lag` runs over 0..15. Antenna i's code is `code_num[8i+7:8i]`.
- R6: Periods follow each other with no gap. Samples after a period's end feed both that period's upper lags and the next period's sums, and every period's taps follow R2.
- R7: Clocks with `smp_stb` low have no effect on the sums.
- R8: When the low four bits of the code numbers are not all equal, `cfg_err` is 1 from the next clock. While it is 1, `tap_vld` stays 0 and `tap_re`/`tap_im` keep their values.
- R9: For periods longer than 256 chips, the code bit uses the chip index modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe |
| smp_re | input | 10 | Received sample, real part, signed |
| smp_im | input | 10 | Received sample, imaginary part, signed |
| pn_chip | input | 1 | Scrambling chip (1 means −1) |
| code_num | input | 32 | Four 8-bit spreading-code numbers, antenna 0 in the low byte |
| blk_cfg | input | 8 | Block count R for the next period |
| cfg_err | output | 1 | Low code bits disagree |
| tap_vld | output | 1 | Tap output valid |
| tap_ant | output | 2 | Antenna of the current tap |
| tap_lag | output | 4 | Lag of the current tap |
| tap_re | output | 24 | Tap value, real part, signed |
| tap_im | output | 24 | Tap value, imaginary part, signed |

## Verification
The hardest case to reach is the period seam. There, the final block's upper lags are still summing samples that already belong to the next period, and a new block count is taking effect at the same time. The stimulus feeds an unbroken sample stream over several periods and changes `blk_cfg` in the middle of the first period. It also runs one period of 320 chips so that the code index wraps past 256. Every streamed tap is compared with a direct correlation that the bench computes from its own stored samples.

// File: rtl/ce_pkg.sv
package ce_pkg;
    localparam int L     = 16;
    localparam int LOG_L = $clog2(L);
    localparam int NTX   = 4;
    localparam int ANT_W = $clog2(NTX);
    localparam int XW    = 10;
    localparam int AW    = 24;
    localparam int CW    = 8;
    localparam int HW    = CW - LOG_L;
    localparam int RW    = 8;
    localparam int FW    = XW + LOG_L + 1;
    localparam int R_MIN = NTX + 1;
    localparam int SW    = $clog2(NTX * L);

    typedef struct packed {
        logic signed [XW-1:0] re;
        logic signed [XW-1:0] im;
    } smp_t;

    typedef struct packed {
        logic signed [FW-1:0] re;
        logic signed [FW-1:0] im;
    } fir_t;

    typedef struct packed {
        logic signed [AW-1:0] re;
        logic signed [AW-1:0] im;
    } acc_t;

    typedef struct packed {
        logic [RW-1:0] idx;
        logic          first;
        logic          last;
    } blk_t;

    function automatic logic [RW-1:0] len_floor(input logic [RW-1:0] r);
        return (r < RW'(R_MIN)) ? RW'(R_MIN) : r;
    endfunction

    function automatic logic signed [FW-1:0] sx_fir(input logic signed [XW-1:0] v);
        return {{(FW-XW){v[XW-1]}}, v};
    endfunction

    function automatic logic signed [AW-1:0] sx_acc(input logic signed [FW-1:0] v);
        return {{(AW-FW){v[FW-1]}}, v};
    endfunction
endpackage

// File: rtl/ce_chip_seq.sv
module ce_chip_seq
    import ce_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic             pn,
    input  logic [LOG_L-1:0] code_lo,
    input  logic [RW-1:0]    cfg_r,
    output logic             chip,
    output logic             blk_end,
    output logic [LOG_L-1:0] lag_nx,
    output blk_t             blk
);
    logic [LOG_L-1:0] l_pos;
    logic [RW-1:0]    r_pos;
    logic [RW-1:0]    r_len;
    logic             l_top;
    logic             r_top;

    always_comb begin
        l_top     = (l_pos == LOG_L'(L-1));
        r_top     = (r_pos == r_len - 1'b1);
        chip      = pn ^ (^(l_pos & code_lo));
        blk_end   = stb && l_top;
        lag_nx    = l_top ? '0 : l_pos + 1'b1;
        blk.idx   = r_pos;
        blk.first = (r_pos == '0);
        blk.last  = r_top;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            l_pos <= '0;
            r_pos <= '0;
            r_len <= len_floor(cfg_r);
        end else if (stb) begin
            if (l_top) begin
                l_pos <= '0;
                if (r_top) begin
                    r_pos <= '0;
                    r_len <= len_floor(cfg_r);
                end else begin
                    r_pos <= r_pos + 1'b1;
                end
            end else begin
                l_pos <= l_pos + 1'b1;
            end
        end
    end

    a_r4_len_floor: assert property (@(posedge clk) disable iff (rst)
        r_len >= RW'(R_MIN));

    a_r3_blk_range: assert property (@(posedge clk) disable iff (rst)
        r_pos < r_len);
endmodule

// File: rtl/ce_shared_fir.sv
module ce_shared_fir
    import ce_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  smp_t             smp,
    input  logic             chip,
    input  logic             blk_end,
    input  logic [LOG_L-1:0] lag_nx,
    input  blk_t             blk_in,
    output fir_t             fir,
    output logic             go,
    output logic [LOG_L-1:0] go_lag,
    output blk_t             go_blk
);
    smp_t       win [L];
    logic [L-1:0] refc;
    logic [L-1:0] coef;
    logic       coef_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < L; j++) win[j] <= '0;
            refc    <= '0;
            coef    <= '0;
            coef_ok <= 1'b0;
            go      <= 1'b0;
            go_lag  <= '0;
            go_blk  <= '0;
        end else begin
            go <= stb && (coef_ok || blk_end);
            if (stb) begin
                win[0] <= smp;
                for (int j = 1; j < L; j++) win[j] <= win[j-1];
                refc   <= {refc[L-2:0], chip};
                go_lag <= lag_nx;
                if (blk_end) begin
                    coef[L-1] <= chip;
                    for (int m = 0; m < L-1; m++) coef[m] <= refc[L-2-m];
                    coef_ok <= 1'b1;
                    go_blk  <= blk_in;
                end
            end
        end
    end

    always_comb begin
        logic signed [FW-1:0] sr;
        logic signed [FW-1:0] si;
        sr = '0;
        si = '0;
        for (int l = 0; l < L; l++) begin
            if (coef[l]) begin
                sr = sr - sx_fir(win[L-1-l].re);
                si = si - sx_fir(win[L-1-l].im);
            end else begin
                sr = sr + sx_fir(win[L-1-l].re);
                si = si + sx_fir(win[L-1-l].im);
            end
        end
        fir.re = sr;
        fir.im = si;
    end

    a_r2_go_has_coef: assert property (@(posedge clk) disable iff (rst)
        go |-> coef_ok);
endmodule

// File: rtl/ce_corr_lane.sv
module ce_corr_lane
    import ce_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [LOG_L-1:0] go_lag,
    input  blk_t             blk,
    input  logic [HW-1:0]    code_hi,
    input  fir_t             fir,
    input  logic [LOG_L-1:0] rd_lag,
    output acc_t             rd_val
);
    acc_t acc  [L];
    acc_t keep [L];
    logic flip;
    acc_t term;
    acc_t sum;

    always_comb begin
        flip    = ^(blk.idx[HW-1:0] & code_hi);
        term.re = flip ? -sx_acc(fir.re) : sx_acc(fir.re);
        term.im = flip ? -sx_acc(fir.im) : sx_acc(fir.im);
        sum.re  = blk.first ? term.re : acc[go_lag].re + term.re;
        sum.im  = blk.first ? term.im : acc[go_lag].im + term.im;
        rd_val  = keep[rd_lag];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < L; j++) begin
                acc[j]  <= '0;
                keep[j] <= '0;
            end
        end else if (go) begin
            acc[go_lag] <= sum;
            if (blk.last) keep[go_lag] <= sum;
        end
    end
endmodule

// File: rtl/ce_tap_stream.sv
module ce_tap_stream
    import ce_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               hold,
    input  acc_t [NTX-1:0]     vals,
    output logic [LOG_L-1:0]   rd_lag,
    output logic               tap_vld,
    output logic [ANT_W-1:0]   tap_ant,
    output logic [LOG_L-1:0]   tap_lag,
    output acc_t               tap
);
    logic [SW-1:0]    cnt;
    logic             on;
    logic [ANT_W-1:0] ant;

    always_comb begin
        ant    = cnt[SW-1:LOG_L];
        rd_lag = cnt[LOG_L-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            on      <= 1'b0;
            tap_vld <= 1'b0;
            tap_ant <= '0;
            tap_lag <= '0;
            tap     <= '0;
        end else begin
            tap_vld <= 1'b0;
            if (on) begin
                if (!hold) begin
                    tap_vld <= 1'b1;
                    tap     <= vals[ant];
                    tap_ant <= ant;
                    tap_lag <= rd_lag;
                end
                cnt <= cnt + 1'b1;
                if (cnt == SW'(NTX*L-1)) on <= 1'b0;
            end
            if (start) begin
                on  <= 1'b1;
                cnt <= '0;
            end
        end
    end

    a_r5_lag_step: assert property (@(posedge clk) disable iff (rst)
        (tap_vld && $past(tap_vld)) |-> (tap_lag == LOG_L'($past(tap_lag) + 1'b1)));

    a_r5_ant_step: assert property (@(posedge clk) disable iff (rst)
        (tap_vld && $past(tap_vld) && tap_lag == '0) |-> (tap_ant == ANT_W'($past(tap_ant) + 1'b1)));
endmodule

// File: rtl/pilot_chan_est.sv
module pilot_chan_est
    import ce_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_stb,
    input  logic [XW-1:0]         smp_re,
    input  logic [XW-1:0]         smp_im,
    input  logic                  pn_chip,
    input  logic [NTX*CW-1:0]     code_num,
    input  logic [RW-1:0]         blk_cfg,
    output logic                  cfg_err,
    output logic                  tap_vld,
    output logic [ANT_W-1:0]      tap_ant,
    output logic [LOG_L-1:0]      tap_lag,
    output logic [AW-1:0]         tap_re,
    output logic [AW-1:0]         tap_im
);
    smp_t             smp;
    logic             chip;
    logic             blk_end;
    logic [LOG_L-1:0] lag_nx;
    blk_t             blk_cur;
    fir_t             fir;
    logic             go;
    logic [LOG_L-1:0] go_lag;
    blk_t             go_blk;
    logic [LOG_L-1:0] rd_lag;
    acc_t [NTX-1:0]   vals;
    acc_t             tap;
    logic             mismatch;
    logic             start;

    assign smp.re = smp_re;
    assign smp.im = smp_im;

    always_comb begin
        mismatch = 1'b0;
        for (int i = 1; i < NTX; i++)
            if (code_num[i*CW +: LOG_L] != code_num[LOG_L-1:0]) mismatch = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_err <= 1'b0;
        else     cfg_err <= mismatch;
    end

    assign start = go && go_blk.last && (go_lag == LOG_L'(L-1));

    ce_chip_seq u_seq (
        .clk(clk), .rst(rst), .stb(smp_stb), .pn(pn_chip),
        .code_lo(code_num[LOG_L-1:0]), .cfg_r(blk_cfg),
        .chip(chip), .blk_end(blk_end), .lag_nx(lag_nx), .blk(blk_cur)
    );

    ce_shared_fir u_fir (
        .clk(clk), .rst(rst), .stb(smp_stb), .smp(smp), .chip(chip),
        .blk_end(blk_end), .lag_nx(lag_nx), .blk_in(blk_cur),
        .fir(fir), .go(go), .go_lag(go_lag), .go_blk(go_blk)
    );

    for (genvar i = 0; i < NTX; i++) begin : g_lane
        ce_corr_lane u_lane (
            .clk(clk), .rst(rst), .go(go), .go_lag(go_lag), .blk(go_blk),
            .code_hi(code_num[i*CW+LOG_L +: HW]), .fir(fir),
            .rd_lag(rd_lag), .rd_val(vals[i])
        );
    end

    ce_tap_stream u_out (
        .clk(clk), .rst(rst), .start(start), .hold(cfg_err), .vals(vals),
        .rd_lag(rd_lag), .tap_vld(tap_vld), .tap_ant(tap_ant),
        .tap_lag(tap_lag), .tap(tap)
    );

    assign tap_re = tap.re;
    assign tap_im = tap.im;

    a_r8_quiet_after_err: assert property (@(posedge clk) disable iff (rst)
        tap_vld |-> !$past(cfg_err));

    a_r8_hold_value: assert property (@(posedge clk) disable iff (rst)
        !tap_vld |-> $stable(tap_re) && $stable(tap_im));
endmodule

// File: tb/pilot_chan_est_test.sv
module pilot_chan_est_test;
    localparam int L = 16;
    localparam int NTX = 4;
    localparam int CW = 8;
    localparam int NS = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_stb = 1'b0;
    logic [9:0] smp_re = '0;
    logic [9:0] smp_im = '0;
    logic pn_chip = 1'b0;
    logic [NTX*CW-1:0] code_num = '0;
    logic [7:0] blk_cfg = 8'd5;
    logic cfg_err, tap_vld;
    logic [1:0] tap_ant;
    logic [3:0] tap_lag;
    logic [23:0] tap_re, tap_im;

    int xr [NS];
    int xi [NS];
    bit pnb [NS];
    logic [CW-1:0] codes [NTX];
    int pstart [8];
    int plen [8];
    int np_cur = 0;
    int mon_p = 0, mon_i = 0, vld_seen = 0;
    int checks = 0, errors = 0;
    int cycles = 0;
    int unsigned seed = 32'h1234_5678;
    string cur_tag = "R2";

    pilot_chan_est uut (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_re(smp_re), .smp_im(smp_im),
        .pn_chip(pn_chip), .code_num(code_num), .blk_cfg(blk_cfg),
        .cfg_err(cfg_err), .tap_vld(tap_vld), .tap_ant(tap_ant), .tap_lag(tap_lag),
        .tap_re(tap_re), .tap_im(tap_im)
    );

    always #2.5 clk = ~clk;

    function automatic int clampi(input int r);
        return (r < 5) ? 5 : r;
    endfunction

    function automatic longint exp_tap(input int p, input int ant, input int lag, input bit im);
        longint s = 0;
        for (int k = 0; k < plen[p]; k++) begin
            logic [7:0] kb = k[7:0];
            int n = pstart[p] + k + lag;
            bit c = pnb[pstart[p] + k] ^ (^(kb & codes[ant]));
            int v = im ? xi[n] : xr[n];
            s += c ? -v : v;
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && tap_vld) begin
            vld_seen++;
            if (mon_p >= np_cur) begin
                check(1'b0, {cur_tag, " extra tap"}, mon_p, np_cur);
            end else begin
                int ant = mon_i / L;
                int lag = mon_i % L;
                longint er = exp_tap(mon_p, ant, lag, 1'b0);
                longint ei = exp_tap(mon_p, ant, lag, 1'b1);
                longint gr = longint'($signed(tap_re));
                longint gi = longint'($signed(tap_im));
                check(gr == er, {cur_tag, " tap real"}, gr, er);
                check(gi == ei, {cur_tag, " tap imag"}, gi, ei);
                check(int'(tap_ant) * L + int'(tap_lag) == mon_i, "R5 tap label",
                      int'(tap_ant) * L + int'(tap_lag), mon_i);
            end
            mon_i++;
            if (mon_i == NTX * L) begin
                mon_i = 0;
                mon_p++;
            end
        end
    end

    task automatic set_codes(input logic [CW-1:0] c0, c1, c2, c3);
        codes[0] = c0; codes[1] = c1; codes[2] = c2; codes[3] = c3;
        code_num = {c3, c2, c1, c0};
    endtask

    task automatic run_phase(input string tag, input int r0, input int r1, input int chg,
                             input int np, input bit gaps, input bit expect_out);
        int total;
        cur_tag = tag;
        for (int n = 0; n < NS; n++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            xr[n] = int'((seed >> 16) & 32'd1023) - 512;
            seed = seed * 32'd1103515245 + 32'd12345;
            xi[n] = int'((seed >> 16) & 32'd1023) - 512;
            pnb[n] = seed[27];
        end
        pstart[0] = 0;
        plen[0] = 16 * clampi(r0);
        for (int p = 1; p < np; p++) begin
            pstart[p] = pstart[p-1] + plen[p-1];
            plen[p] = 16 * clampi(r1);
        end
        total = pstart[np-1] + plen[np-1] + L - 1;
        np_cur = np;
        blk_cfg = 8'(r0);
        smp_stb = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tap_vld == 1'b0 && tap_re == '0 && tap_im == '0, "R1 reset outputs",
              longint'(tap_vld), 0);
        rst = 1'b0;
        mon_p = 0; mon_i = 0; vld_seen = 0;
        for (int s = 0; s < total; s++) begin
            if (gaps && (s % 3 == 1)) begin
                smp_stb = 1'b0;
                smp_re = 10'h155;
                @(negedge clk);
            end
            if (s == chg) blk_cfg = 8'(r1);
            smp_stb = 1'b1;
            smp_re = 10'(xr[s]);
            smp_im = 10'(xi[s]);
            pn_chip = pnb[s];
            @(negedge clk);
            if (s == 0 && expect_out)
                check(cfg_err == 1'b0 && tap_vld == 1'b0, "R1 first clock", longint'(cfg_err), 0);
        end
        smp_stb = 1'b0;
        repeat (160) @(negedge clk);
        if (expect_out) begin
            check(vld_seen == np * NTX * L, {"R5/R6 tap count ", tag}, vld_seen, np * NTX * L);
        end else begin
            check(vld_seen == 0, "R8 no taps on code mismatch", vld_seen, 0);
            check(cfg_err == 1'b1, "R8 error flag", longint'(cfg_err), 1);
            check(tap_re == '0 && tap_im == '0, "R8 taps held", longint'($signed(tap_re)), 0);
        end
    endtask

    initial begin
        set_codes(8'hA6, 8'h16, 8'h76, 8'hC6);
        run_phase("R2", 5, 5, -1, 2, 1'b0, 1'b1);
        set_codes(8'h03, 8'h13, 8'h53, 8'hF3);
        run_phase("R9", 20, 20, -1, 1, 1'b0, 1'b1);
        set_codes(8'h00, 8'h10, 8'h20, 8'h30);
        run_phase("R4", 2, 2, -1, 2, 1'b0, 1'b1);
        set_codes(8'h5B, 8'hEB, 8'h2B, 8'h9B);
        run_phase("R3", 5, 7, 10, 3, 1'b0, 1'b1);
        set_codes(8'h71, 8'h81, 8'h41, 8'hD1);
        run_phase("R7", 9, 9, -1, 2, 1'b1, 1'b1);
        set_codes(8'h01, 8'h12, 8'h21, 8'h31);
        run_phase("R8", 5, 5, -1, 1, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end
endmodule